// File: doc/BRIEF.md
# Accelerator Control Register Slave

This block sits between a processor's AXI4-Lite bus and a fixed-function compute core. Software uses it to load three argument bytes, launch the core, and collect a one-byte result. Launches can be single-shot or free-running. Completion and hand-over events can be reported through a single level-sensitive interrupt line.

On the core side the block drives a start request and the latched argument values. It observes the core's done, idle and ready signals, and it captures the result whenever the core flags it as valid.

The register bits do not all behave alike. The launch bit clears itself. The completion flag and the result-valid flag clear when software reads them. Interrupt status bits flip when software writes a 1 to them. The free-running bit keeps the start request asserted across every hand-over.

The word offsets software sees are 0x00 control, 0x04 global interrupt enable, 0x08 channel enables, 0x0C interrupt status, 0x10/0x18/0x20 arguments a/b/c, 0x28 result and 0x2C result-valid.

Top module: `accel_ctl_regs`

## Requirements
- R1: After reset, every register reads zero except the live idle and ready bits. `core_start`, `irq`, `bvalid`, `rvalid` and all argument outputs are 0.
- R2: Writing a 1 to control bit 0 raises `core_start` once the write completes, and bit 0 reads back as 1. With bit 7 clear, `core_start` drops after the first cycle in which `core_ready` is high. Writing 0 to bit 0 does not stop a pending launch.
- R3: Control bit 7 (free-running) keeps `core_start` high through each `core_ready` cycle. After software clears bit 7, the next `core_ready` drops `core_start`.
- R4: Control bit 1 is set by a `core_done` pulse and stays set until the control register is read. That read still returns the bit as 1, and the next read returns it as 0.
- R5: Control bit 2 reads the live `core_idle` input and bit 3 reads the live `core_ready` input. Bits 4 to 6 and 8 upward read zero.
- R6: Interrupt status bit 0 latches a `core_done` pulse and bit 1 latches a `core_ready` pulse, each only while the matching enable bit at 0x08 is set (bit 0 for done, bit 1 for ready). Writing a 1 to a status bit inverts it, and writing 0 leaves it unchanged.
- R7: `irq` is high exactly when 0x04 bit 0 is set and some status bit is set together with its enable.
- R8: The argument bytes at 0x10, 0x18 and 0x20 (bits 7:0) read back what was written. `arg_a`, `arg_b` and `arg_c` take the stored values only when a launch is accepted: a software start from rest, or a free-running hand-over. Argument writes during a run leave the outputs unchanged.
- R9: A `core_result_vld` cycle stores `core_result` at 0x28 and sets 0x2C bit 0. Reading 0x2C returns 1 and clears the flag.
- R10: Reads of 0x14, 0x1C, 0x24, 0x30 to 0x3C return zero. Writes there change nothing. Every response is OKAY (0).
- R11: A write whose byte-0 strobe is low leaves bits 7:0 of the target register unchanged.
- R12: The write address and write data may arrive in either order and in different cycles. `bvalid` stays high until `bready`. `rvalid` and `rdata` stay stable until `rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Synchronous active-low reset |
| s_axi_awaddr | input | ADDR_W | Write byte address |
| s_axi_awvalid | input | 1 | Write address valid |
| s_axi_awready | output | 1 | Write address accepted |
| s_axi_wdata | input | DATA_W | Write data |
| s_axi_wstrb | input | DATA_W/8 | Write byte strobes |
| s_axi_wvalid | input | 1 | Write data valid |
| s_axi_wready | output | 1 | Write data accepted |
| s_axi_bresp | output | 2 | Write response, always OKAY |
| s_axi_bvalid | output | 1 | Write response valid |
| s_axi_bready | input | 1 | Write response taken |
| s_axi_araddr | input | ADDR_W | Read byte address |
| s_axi_arvalid | input | 1 | Read address valid |
| s_axi_arready | output | 1 | Read address accepted |
| s_axi_rdata | output | DATA_W | Read data |
| s_axi_rresp | output | 2 | Read response, always OKAY |
| s_axi_rvalid | output | 1 | Read data valid |
| s_axi_rready | input | 1 | Read data taken |
| core_start | output | 1 | Launch request to the core |
| core_done | input | 1 | Core finished a run (pulse) |
| core_idle | input | 1 | Core is idle (level) |
| core_ready | input | 1 | Core took its inputs (pulse) |
| arg_a | output | ARG_W | Latched argument a |
| arg_b | output | ARG_W | Latched argument b |
| arg_c | output | ARG_W | Latched argument c |
| core_result | input | ARG_W | Result from the core |
| core_result_vld | input | 1 | Result valid strobe |
| irq | output | 1 | Level interrupt |

## Verification
Most faults in this block show up within one or two cycles at the ports.

- A start flag that fails to clear, or clears early, shows on `core_start` in the cycle after the `core_ready` pulse.
- A completion or result-valid flag that is not sticky, or is cleared at the wrong moment, shows up on the next pair of reads of its register.
- A corrupted status or enable bit is visible on `irq` in the cycle after the event or write.
- Arguments latched at the wrong moment appear on `arg_a`..`arg_c` as soon as the launch or hand-over edge has passed.

// File: rtl/accel_ctl_pkg.sv
package accel_ctl_pkg;

    localparam logic [7:0] OFF_CTRL    = 8'h00;
    localparam logic [7:0] OFF_GIE     = 8'h04;
    localparam logic [7:0] OFF_IER     = 8'h08;
    localparam logic [7:0] OFF_ISR     = 8'h0C;
    localparam logic [7:0] OFF_ARG_A   = 8'h10;
    localparam logic [7:0] OFF_ARG_B   = 8'h18;
    localparam logic [7:0] OFF_ARG_C   = 8'h20;
    localparam logic [7:0] OFF_RES     = 8'h28;
    localparam logic [7:0] OFF_RES_VLD = 8'h2C;

    localparam int BIT_START = 0;
    localparam int BIT_DONE  = 1;
    localparam int BIT_IDLE  = 2;
    localparam int BIT_READY = 3;
    localparam int BIT_AUTO  = 7;

    localparam int NUM_IRQ_CH = 2;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_GIE,
        SEL_IER,
        SEL_ISR,
        SEL_ARG_A,
        SEL_ARG_B,
        SEL_ARG_C,
        SEL_RES,
        SEL_RES_VLD
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [31:0] byte_addr);
        reg_sel_e s;
        s = SEL_NONE;
        if (byte_addr[31:8] == '0) begin
            case ({byte_addr[7:2], 2'b00})
                OFF_CTRL:    s = SEL_CTRL;
                OFF_GIE:     s = SEL_GIE;
                OFF_IER:     s = SEL_IER;
                OFF_ISR:     s = SEL_ISR;
                OFF_ARG_A:   s = SEL_ARG_A;
                OFF_ARG_B:   s = SEL_ARG_B;
                OFF_ARG_C:   s = SEL_ARG_C;
                OFF_RES:     s = SEL_RES;
                OFF_RES_VLD: s = SEL_RES_VLD;
                default:     s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/acr_axil_wr.sv
module acr_axil_wr #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb
);

    typedef struct packed {
        logic              aw_held;
        logic              w_held;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
        logic              bvalid;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        awready = !st_q.aw_held;
        wready  = !st_q.w_held;
        wr_fire = st_q.aw_held && st_q.w_held && !st_q.bvalid;
        if (awvalid && !st_q.aw_held) begin
            st_d.aw_held = 1'b1;
            st_d.addr    = awaddr;
        end
        if (wvalid && !st_q.w_held) begin
            st_d.w_held = 1'b1;
            st_d.data   = wdata;
            st_d.strb   = wstrb;
        end
        if (st_q.bvalid && bready) begin
            st_d.bvalid = 1'b0;
        end
        if (wr_fire) begin
            st_d.aw_held = 1'b0;
            st_d.w_held  = 1'b0;
            st_d.bvalid  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bvalid  = st_q.bvalid;
    assign wr_addr = st_q.addr;
    assign wr_data = st_q.data;
    assign wr_strb = st_q.strb;

endmodule

// File: rtl/acr_axil_rd.sv
module acr_axil_rd #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic              rready,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_word
);

    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        arready = !st_q.rvalid;
        rd_fire = arvalid && !st_q.rvalid;
        rd_addr = araddr;
        if (st_q.rvalid && rready) begin
            st_d.rvalid = 1'b0;
        end
        if (rd_fire) begin
            st_d.rvalid = 1'b1;
            st_d.data   = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rvalid = st_q.rvalid;
    assign rdata  = st_q.data;

endmodule

// File: rtl/acr_regfile.sv
module acr_regfile
    import accel_ctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int ARG_W  = 8,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic              core_start,
    input  logic              core_done,
    input  logic              core_idle,
    input  logic              core_ready,
    output logic [ARG_W-1:0]  arg_a,
    output logic [ARG_W-1:0]  arg_b,
    output logic [ARG_W-1:0]  arg_c,
    input  logic [ARG_W-1:0]  core_result,
    input  logic              core_result_vld,
    output logic              irq,
    output logic              st_auto,
    output logic              st_done,
    output logic              st_gie,
    output logic [NUM_IRQ_CH-1:0] st_ier,
    output logic              st_res_vld,
    output logic              sw_start,
    output logic              ctrl_rd
);

    typedef struct packed {
        logic                  start;
        logic                  done;
        logic                  auto_rs;
        logic                  gie;
        logic [NUM_IRQ_CH-1:0] ier;
        logic [NUM_IRQ_CH-1:0] isr;
        logic [ARG_W-1:0]      a;
        logic [ARG_W-1:0]      b;
        logic [ARG_W-1:0]      c;
        logic [ARG_W-1:0]      la;
        logic [ARG_W-1:0]      lb;
        logic [ARG_W-1:0]      lc;
        logic [ARG_W-1:0]      res;
        logic                  res_vld;
    } regs_t;

    regs_t q, d;

    reg_sel_e              wsel;
    reg_sel_e              rsel;
    logic                  wen0;
    logic [DATA_W-1:0]     bmask;
    logic [ARG_W-1:0]      amask;
    logic                  hw_accept;
    logic                  launch;
    logic [NUM_IRQ_CH-1:0] tog;
    logic [NUM_IRQ_CH-1:0] events;

    // expand byte strobes into a bit mask
    generate
        for (genvar g = 0; g < STRB_W; g++) begin : g_mask
            assign bmask[g*8 +: 8] = {8{wr_strb[g]}};
        end
    endgenerate
    assign amask = bmask[ARG_W-1:0];

    always_comb begin
        d         = q;
        wsel      = decode_sel(32'(wr_addr));
        rsel      = decode_sel(32'(rd_addr));
        wen0      = wr_fire && wr_strb[0];
        sw_start  = wen0 && (wsel == SEL_CTRL) && wr_data[BIT_START];
        ctrl_rd   = rd_fire && (rsel == SEL_CTRL);
        hw_accept = q.start && core_ready;
        launch    = (sw_start && (!q.start || core_ready)) ||
                    (hw_accept && q.auto_rs);

        // launch request: hardware clear, software set wins
        if (hw_accept && !q.auto_rs) d.start = 1'b0;
        if (sw_start)                d.start = 1'b1;

        if (launch) begin
            d.la = q.a;
            d.lb = q.b;
            d.lc = q.c;
        end

        if (wen0) begin
            case (wsel)
                SEL_CTRL: d.auto_rs = wr_data[BIT_AUTO];
                SEL_GIE:  d.gie     = wr_data[0];
                SEL_IER:  d.ier     = wr_data[NUM_IRQ_CH-1:0];
                default:  ;
            endcase
        end
        if (wr_fire) begin
            case (wsel)
                SEL_ARG_A: d.a = (q.a & ~amask) | (wr_data[ARG_W-1:0] & amask);
                SEL_ARG_B: d.b = (q.b & ~amask) | (wr_data[ARG_W-1:0] & amask);
                SEL_ARG_C: d.c = (q.c & ~amask) | (wr_data[ARG_W-1:0] & amask);
                default:   ;
            endcase
        end

        // interrupt status: toggle on write, events take priority
        tog    = (wen0 && wsel == SEL_ISR) ? wr_data[NUM_IRQ_CH-1:0] : '0;
        events = {core_ready, core_done} & q.ier;
        d.isr  = (q.isr ^ tog) | events;

        if (ctrl_rd)   d.done = 1'b0;
        if (core_done) d.done = 1'b1;

        if (rd_fire && rsel == SEL_RES_VLD) d.res_vld = 1'b0;
        if (core_result_vld) begin
            d.res     = core_result;
            d.res_vld = 1'b1;
        end

        // read view
        rd_word = '0;
        case (rsel)
            SEL_CTRL: begin
                rd_word[BIT_START] = q.start;
                rd_word[BIT_DONE]  = q.done;
                rd_word[BIT_IDLE]  = core_idle;
                rd_word[BIT_READY] = core_ready;
                rd_word[BIT_AUTO]  = q.auto_rs;
            end
            SEL_GIE:     rd_word[0] = q.gie;
            SEL_IER:     rd_word[NUM_IRQ_CH-1:0] = q.ier;
            SEL_ISR:     rd_word[NUM_IRQ_CH-1:0] = q.isr;
            SEL_ARG_A:   rd_word[ARG_W-1:0] = q.a;
            SEL_ARG_B:   rd_word[ARG_W-1:0] = q.b;
            SEL_ARG_C:   rd_word[ARG_W-1:0] = q.c;
            SEL_RES:     rd_word[ARG_W-1:0] = q.res;
            SEL_RES_VLD: rd_word[0] = q.res_vld;
            default:     ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign core_start = q.start;
    assign arg_a      = q.la;
    assign arg_b      = q.lb;
    assign arg_c      = q.lc;
    assign irq        = q.gie && |(q.ier & q.isr);
    assign st_auto    = q.auto_rs;
    assign st_done    = q.done;
    assign st_gie     = q.gie;
    assign st_ier     = q.ier;
    assign st_res_vld = q.res_vld;

endmodule

// File: rtl/accel_ctl_regs.sv
module accel_ctl_regs
    import accel_ctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int ARG_W  = 8,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              aclk,
    input  logic              aresetn,
    input  logic [ADDR_W-1:0] s_axi_awaddr,
    input  logic              s_axi_awvalid,
    output logic              s_axi_awready,
    input  logic [DATA_W-1:0] s_axi_wdata,
    input  logic [STRB_W-1:0] s_axi_wstrb,
    input  logic              s_axi_wvalid,
    output logic              s_axi_wready,
    output logic [1:0]        s_axi_bresp,
    output logic              s_axi_bvalid,
    input  logic              s_axi_bready,
    input  logic [ADDR_W-1:0] s_axi_araddr,
    input  logic              s_axi_arvalid,
    output logic              s_axi_arready,
    output logic [DATA_W-1:0] s_axi_rdata,
    output logic [1:0]        s_axi_rresp,
    output logic              s_axi_rvalid,
    input  logic              s_axi_rready,
    output logic              core_start,
    input  logic              core_done,
    input  logic              core_idle,
    input  logic              core_ready,
    output logic [ARG_W-1:0]  arg_a,
    output logic [ARG_W-1:0]  arg_b,
    output logic [ARG_W-1:0]  arg_c,
    input  logic [ARG_W-1:0]  core_result,
    input  logic              core_result_vld,
    output logic              irq
);

    logic                  wr_fire;
    logic [ADDR_W-1:0]     wr_addr;
    logic [DATA_W-1:0]     wr_data;
    logic [STRB_W-1:0]     wr_strb;
    logic                  rd_fire;
    logic [ADDR_W-1:0]     rd_addr;
    logic [DATA_W-1:0]     rd_word;
    logic                  st_auto;
    logic                  st_done;
    logic                  st_gie;
    logic [NUM_IRQ_CH-1:0] st_ier;
    logic                  st_res_vld;
    logic                  sw_start;
    logic                  ctrl_rd;

    assign s_axi_bresp = 2'b00;
    assign s_axi_rresp = 2'b00;

    acr_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk     (aclk),
        .rst_n   (aresetn),
        .awaddr  (s_axi_awaddr),
        .awvalid (s_axi_awvalid),
        .awready (s_axi_awready),
        .wdata   (s_axi_wdata),
        .wstrb   (s_axi_wstrb),
        .wvalid  (s_axi_wvalid),
        .wready  (s_axi_wready),
        .bvalid  (s_axi_bvalid),
        .bready  (s_axi_bready),
        .wr_fire (wr_fire),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_strb (wr_strb)
    );

    acr_axil_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk     (aclk),
        .rst_n   (aresetn),
        .araddr  (s_axi_araddr),
        .arvalid (s_axi_arvalid),
        .arready (s_axi_arready),
        .rdata   (s_axi_rdata),
        .rvalid  (s_axi_rvalid),
        .rready  (s_axi_rready),
        .rd_fire (rd_fire),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    acr_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARG_W(ARG_W)) u_regs (
        .clk             (aclk),
        .rst_n           (aresetn),
        .wr_fire         (wr_fire),
        .wr_addr         (wr_addr),
        .wr_data         (wr_data),
        .wr_strb         (wr_strb),
        .rd_fire         (rd_fire),
        .rd_addr         (rd_addr),
        .rd_word         (rd_word),
        .core_start      (core_start),
        .core_done       (core_done),
        .core_idle       (core_idle),
        .core_ready      (core_ready),
        .arg_a           (arg_a),
        .arg_b           (arg_b),
        .arg_c           (arg_c),
        .core_result     (core_result),
        .core_result_vld (core_result_vld),
        .irq             (irq),
        .st_auto         (st_auto),
        .st_done         (st_done),
        .st_gie          (st_gie),
        .st_ier          (st_ier),
        .st_res_vld      (st_res_vld),
        .sw_start        (sw_start),
        .ctrl_rd         (ctrl_rd)
    );

endmodule

// File: rtl/accel_ctl_regs_chk.sv
module accel_ctl_regs_chk #(
    parameter int DATA_W = 32
) (
    input logic              aclk,
    input logic              aresetn,
    input logic              core_start,
    input logic              core_ready,
    input logic              core_done,
    input logic              core_result_vld,
    input logic              irq,
    input logic              s_axi_bvalid,
    input logic              s_axi_bready,
    input logic              s_axi_rvalid,
    input logic              s_axi_rready,
    input logic [DATA_W-1:0] s_axi_rdata,
    input logic              st_auto,
    input logic              st_done,
    input logic              st_gie,
    input logic [1:0]        st_ier,
    input logic              st_res_vld,
    input logic              sw_start,
    input logic              ctrl_rd,
    input logic              wr_fire
);

    assert_start_selfclear_R2: assert property (@(posedge aclk) disable iff (!aresetn)
        core_start && core_ready && !st_auto && !sw_start |=> !core_start);

    assert_autorestart_hold_R3: assert property (@(posedge aclk) disable iff (!aresetn)
        core_start && core_ready && st_auto |=> core_start);

    assert_done_set_R4: assert property (@(posedge aclk) disable iff (!aresetn)
        core_done |=> st_done);

    assert_done_clear_R4: assert property (@(posedge aclk) disable iff (!aresetn)
        st_done && ctrl_rd && !core_done |=> !st_done);

    assert_irq_on_done_R7: assert property (@(posedge aclk) disable iff (!aresetn)
        core_done && st_ier[0] && st_gie && !wr_fire |=> irq);

    assert_irq_gated_R7: assert property (@(posedge aclk) disable iff (!aresetn)
        !st_gie |-> !irq);

    assert_result_flag_R9: assert property (@(posedge aclk) disable iff (!aresetn)
        core_result_vld |=> st_res_vld);

    assert_bvalid_hold_R12: assert property (@(posedge aclk) disable iff (!aresetn)
        s_axi_bvalid && !s_axi_bready |=> s_axi_bvalid);

    assert_rdata_hold_R12: assert property (@(posedge aclk) disable iff (!aresetn)
        s_axi_rvalid && !s_axi_rready |=> s_axi_rvalid && $stable(s_axi_rdata));

endmodule

bind accel_ctl_regs accel_ctl_regs_chk #(.DATA_W(DATA_W)) u_chk (
    .aclk            (aclk),
    .aresetn         (aresetn),
    .core_start      (core_start),
    .core_ready      (core_ready),
    .core_done       (core_done),
    .core_result_vld (core_result_vld),
    .irq             (irq),
    .s_axi_bvalid    (s_axi_bvalid),
    .s_axi_bready    (s_axi_bready),
    .s_axi_rvalid    (s_axi_rvalid),
    .s_axi_rready    (s_axi_rready),
    .s_axi_rdata     (s_axi_rdata),
    .st_auto         (st_auto),
    .st_done         (st_done),
    .st_gie          (st_gie),
    .st_ier          (st_ier),
    .st_res_vld      (st_res_vld),
    .sw_start        (sw_start),
    .ctrl_rd         (ctrl_rd),
    .wr_fire         (wr_fire)
);

// File: tb/accel_ctl_regs_test.sv
`timescale 1ns/1ps
module accel_ctl_regs_test;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int ARG_W  = 8;

    logic              aclk = 1'b0;
    logic              aresetn = 1'b0;
    logic [ADDR_W-1:0] awaddr = '0;
    logic              awvalid = 1'b0;
    logic              awready;
    logic [DATA_W-1:0] wdata = '0;
    logic [3:0]        wstrb = '0;
    logic              wvalid = 1'b0;
    logic              wready;
    logic [1:0]        bresp;
    logic              bvalid;
    logic              bready = 1'b0;
    logic [ADDR_W-1:0] araddr = '0;
    logic              arvalid = 1'b0;
    logic              arready;
    logic [DATA_W-1:0] rdata;
    logic [1:0]        rresp;
    logic              rvalid;
    logic              rready = 1'b0;
    logic              core_start;
    logic              core_done = 1'b0;
    logic              core_idle = 1'b1;
    logic              core_ready = 1'b0;
    logic [ARG_W-1:0]  arg_a, arg_b, arg_c;
    logic [ARG_W-1:0]  core_result = '0;
    logic              core_result_vld = 1'b0;
    logic              irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic finished = 1'b0;

    always #2.5 aclk = ~aclk;

    accel_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARG_W(ARG_W)) uut (
        .aclk(aclk), .aresetn(aresetn),
        .s_axi_awaddr(awaddr), .s_axi_awvalid(awvalid), .s_axi_awready(awready),
        .s_axi_wdata(wdata), .s_axi_wstrb(wstrb), .s_axi_wvalid(wvalid),
        .s_axi_wready(wready), .s_axi_bresp(bresp), .s_axi_bvalid(bvalid),
        .s_axi_bready(bready), .s_axi_araddr(araddr), .s_axi_arvalid(arvalid),
        .s_axi_arready(arready), .s_axi_rdata(rdata), .s_axi_rresp(rresp),
        .s_axi_rvalid(rvalid), .s_axi_rready(rready),
        .core_start(core_start), .core_done(core_done), .core_idle(core_idle),
        .core_ready(core_ready), .arg_a(arg_a), .arg_b(arg_b), .arg_c(arg_c),
        .core_result(core_result), .core_result_vld(core_result_vld), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic axi_write(input logic [7:0] addr, input logic [31:0] data,
                             input logic [3:0] strb);
        @(negedge aclk);
        awaddr = addr[ADDR_W-1:0]; wdata = data; wstrb = strb;
        awvalid = 1'b1; wvalid = 1'b1;
        @(posedge aclk);
        @(negedge aclk);
        awvalid = 1'b0; wvalid = 1'b0;
        while (!bvalid) @(negedge aclk);
        check("R10 bresp", 32'(bresp), 32'h0);
        bready = 1'b1;
        @(negedge aclk);
        bready = 1'b0;
    endtask

    task automatic axi_read(input logic [7:0] addr, output logic [31:0] data);
        @(negedge aclk);
        araddr = addr[ADDR_W-1:0]; arvalid = 1'b1;
        @(posedge aclk);
        @(negedge aclk);
        arvalid = 1'b0;
        while (!rvalid) @(negedge aclk);
        data = rdata;
        check("R10 rresp", 32'(rresp), 32'h0);
        rready = 1'b1;
        @(negedge aclk);
        rready = 1'b0;
    endtask

    task automatic pulse_ready();
        @(negedge aclk); core_ready = 1'b1;
        @(negedge aclk); core_ready = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge aclk); core_done = 1'b1;
        @(negedge aclk); core_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 core_start", 32'(core_start), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 arg_a", 32'(arg_a), 0);
        check("R1 bvalid/rvalid", {30'd0, bvalid, rvalid}, 0);
        axi_read(8'h00, v); check("R1/R5 ctrl idle only", v, 32'h4);
        axi_read(8'h0C, v); check("R1 isr", v, 0);
        axi_read(8'h2C, v); check("R1 res_vld", v, 0);
    endtask

    task automatic t_args();
        logic [31:0] v;
        axi_write(8'h10, 32'hFFFF_FF11, 4'hF);
        axi_write(8'h18, 32'h22, 4'hF);
        axi_write(8'h20, 32'h33, 4'hF);
        axi_read(8'h10, v); check("R8 arg a readback", v, 32'h11);
        axi_read(8'h18, v); check("R8 arg b readback", v, 32'h22);
        axi_read(8'h20, v); check("R8 arg c readback", v, 32'h33);
        check("R8 no load before start", 32'(arg_a), 0);
        axi_write(8'h10, 32'hEE, 4'hE);
        axi_read(8'h10, v); check("R11 strobe low ignored", v, 32'h11);
    endtask

    task automatic t_single_run();
        logic [31:0] v;
        axi_write(8'h00, 32'h1, 4'h1);
        check("R2 start raised", 32'(core_start), 1);
        check("R8 args latched", {8'd0, arg_a, arg_b, arg_c}, 32'h112233);
        axi_read(8'h00, v); check("R2 start readback", v, 32'h5);
        axi_write(8'h00, 32'h0, 4'h1);
        check("R2 write 0 keeps start", 32'(core_start), 1);
        axi_write(8'h10, 32'h55, 4'h1);
        check("R8 write during run ignored", 32'(arg_a), 32'h11);
        pulse_ready();
        check("R2 start self-clear", 32'(core_start), 0);
        @(negedge aclk); core_idle = 1'b0; core_ready = 1'b1;
        axi_read(8'h00, v); check("R5 live idle/ready", v, 32'h8);
        core_ready = 1'b0; core_idle = 1'b1;
        pulse_done();
        axi_read(8'h00, v); check("R4 done visible", v, 32'h6);
        axi_read(8'h00, v); check("R4 done cleared by read", v, 32'h4);
    endtask

    task automatic t_auto();
        logic [31:0] v;
        axi_write(8'h00, 32'h81, 4'h1);
        check("R8 launch loads a", 32'(arg_a), 32'h55);
        axi_write(8'h10, 32'h66, 4'h1);
        pulse_ready();
        check("R3 start held over ready", 32'(core_start), 1);
        check("R8 relaunch loads a", 32'(arg_a), 32'h66);
        axi_read(8'h00, v); check("R3 ctrl auto", v, 32'h85);
        axi_write(8'h00, 32'h0, 4'h1);
        check("R3 start kept after auto clear", 32'(core_start), 1);
        pulse_ready();
        check("R3 stops after auto clear", 32'(core_start), 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        axi_write(8'h08, 32'h3, 4'h1);
        pulse_done();
        axi_read(8'h0C, v); check("R6 done latched", v, 32'h1);
        check("R7 irq gated by gie", 32'(irq), 0);
        axi_write(8'h04, 32'h1, 4'h1);
        check("R7 irq raised", 32'(irq), 1);
        axi_write(8'h0C, 32'h1, 4'h1);
        axi_read(8'h0C, v); check("R6 toggle clears", v, 0);
        check("R7 irq dropped", 32'(irq), 0);
        pulse_ready();
        axi_read(8'h0C, v); check("R6 ready latched", v, 32'h2);
        check("R7 irq on ready", 32'(irq), 1);
        axi_write(8'h0C, 32'h0, 4'h1);
        axi_read(8'h0C, v); check("R6 write 0 no change", v, 32'h2);
        axi_write(8'h0C, 32'h2, 4'h1);
        axi_write(8'h08, 32'h0, 4'h1);
        pulse_done();
        axi_read(8'h0C, v); check("R6 disabled channel", v, 0);
        check("R7 irq low", 32'(irq), 0);
        axi_write(8'h04, 32'h0, 4'h1);
        axi_read(8'h00, v);
    endtask

    task automatic t_result();
        logic [31:0] v;
        @(negedge aclk); core_result = 8'hA5; core_result_vld = 1'b1;
        @(negedge aclk); core_result_vld = 1'b0; core_result = 8'h00;
        axi_read(8'h2C, v); check("R9 valid set", v, 1);
        axi_read(8'h28, v); check("R9 result", v, 32'hA5);
        axi_read(8'h2C, v); check("R9 valid clear on read", v, 0);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        axi_write(8'h14, 32'hFF, 4'hF);
        axi_read(8'h14, v); check("R10 reserved read zero", v, 0);
        axi_read(8'h10, v); check("R10 neighbour untouched", v, 32'h66);
        axi_write(8'h3C, 32'hFF, 4'hF);
        axi_read(8'h3C, v); check("R10 unmapped read zero", v, 0);
        axi_read(8'h00, v); check("R10 ctrl untouched", v, 32'h4);
    endtask

    task automatic t_handshake();
        logic [31:0] v;
        @(negedge aclk);
        awaddr = 6'h18; awvalid = 1'b1;
        @(posedge aclk);
        @(negedge aclk);
        awvalid = 1'b0;
        repeat (3) @(negedge aclk);
        check("R12 aw held, no response", {30'd0, awready, bvalid}, 0);
        wdata = 32'h77; wstrb = 4'h1; wvalid = 1'b1;
        @(posedge aclk);
        @(negedge aclk);
        wvalid = 1'b0;
        @(negedge aclk);
        check("R12 bvalid after late data", 32'(bvalid), 1);
        repeat (3) @(negedge aclk);
        check("R12 bvalid held", 32'(bvalid), 1);
        bready = 1'b1;
        @(negedge aclk);
        bready = 1'b0;
        check("R12 bvalid released", 32'(bvalid), 0);
        @(negedge aclk);
        araddr = 6'h18; arvalid = 1'b1;
        @(posedge aclk);
        @(negedge aclk);
        arvalid = 1'b0;
        repeat (3) @(negedge aclk);
        check("R12 rvalid/rdata held", {rvalid, rdata[30:0]}, 32'h8000_0077);
        rready = 1'b1;
        @(negedge aclk);
        rready = 1'b0;
        check("R12 rvalid released", 32'(rvalid), 0);
        axi_read(8'h18, v); check("R12 out-of-order write landed", v, 32'h77);
    endtask

    initial begin
        repeat (4) @(negedge aclk);
        aresetn = 1'b1;
        @(negedge aclk);
        t_reset();
        t_args();
        t_single_run();
        t_auto();
        t_irq();
        t_result();
        t_reserved();
        t_handshake();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge aclk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule